// File: doc/BRIEF.md
# Audio Link Source Selector

This block puts one of two serial audio links onto the three shared input lines of a converter. One link carries direct stream digital (DSD): a clock, left data and right data. The other link is I2S: a bit clock, a word clock and serial data. Each link also has a flag that shows whether a live signal is present on its cable. A select input picks which link gets the shared lines. When an S/PDIF source is switched in elsewhere, a separate enable takes the shared lines over and forces all three of them low.

A four-state controller, clocked by a system clock, decides which link owns the shared lines:

- **ST_OFF**: nothing is routed.
- **ST_DSD**: the DSD link is routed.
- **ST_I2S**: the I2S link is routed.
- **ST_SWAP**: a one-cycle blanking state, used when the select flips between two live links.

The controller computes a target from the inputs. The target is ST_OFF when S/PDIF is enabled. Otherwise the target is the selected link's route when that link's flag is high, and ST_OFF when it is low.

The controller moves as follows:

- From ST_OFF it goes straight to the target.
- From a route state it goes to ST_SWAP when the target is the other route.
- From a route state it goes to ST_OFF when the target is ST_OFF.
- From ST_SWAP it always goes to the target.

The signal lines themselves pass through AND gates and are never registered. The gate enable combines the registered state with the live activity flag and the S/PDIF enable. The valid flag and the format flag are decoded from the state register.

Top module: `audio_link_selector`

## Requirements
- R1: While reset is asserted and after its release, until the first route is taken, link_valid is 0, fmt_dsd is 0 and link_out is 3'b000.
- R2: On a DSD route, the shared lines carry the DSD lines in place: link_out[0]=clock, link_out[1]=left data, link_out[2]=right data, taken from dsd_in[0], dsd_in[1] and dsd_in[2].
- R3: On an I2S route, link_out[0]=bit clock, link_out[1]=word clock, link_out[2]=serial data, taken from i2s_in[0], i2s_in[1] and i2s_in[2].
- R4: spdif_en high drives link_out to 3'b000 in the same cycle. link_valid is 0 after the next clock edge.
- R5: If the routed link's activity flag drops, link_out goes to 3'b000 in the same cycle. link_valid is 0 after the next clock edge.
- R6: The lines and activity flag of the link that is not selected have no effect on any output.
- R7: When the select flips while both links are live, the first edge enters ST_SWAP (link_valid=0, link_out=3'b000, fmt_dsd=0). The second edge routes the new link.
- R8: fmt_dsd is 1 on a DSD route and 0 on an I2S route. It is 0 whenever link_valid is 0.
- R9: From ST_OFF, a live selected link with spdif_en low is routed after a single clock edge, with no blanking cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the route controller |
| rst_n | input | 1 | Active-low asynchronous reset |
| spdif_en | input | 1 | S/PDIF source switched in; the shared lines are forced low |
| sel_dsd | input | 1 | 1 selects the DSD link, 0 selects the I2S link |
| dsd_active | input | 1 | Live-signal flag from the DSD cable |
| i2s_active | input | 1 | Live-signal flag from the I2S cable |
| dsd_in | input | 3 | DSD lines: [0] clock, [1] left, [2] right |
| i2s_in | input | 3 | I2S lines: [0] bit clock, [1] word clock, [2] data |
| link_out | output | 3 | Shared converter input lines |
| fmt_dsd | output | 1 | 1 while a DSD route is valid, else 0 |
| link_valid | output | 1 | A route is established and its link is live |

## Verification
The assertions check the following on every cycle:

- The shared lines are zero whenever S/PDIF is enabled or no route is valid.
- The lines equal the routed link's lines while that link is live.
- A select flip from a valid route is followed by an invalid cycle.
- The format flag is 0 whenever valid is low.

Only the bench's scenarios can show the following:

- Every combination of controls and line values settles to the correct route.
- The exact two-edge timing of a swap.
- The single-edge entry from ST_OFF.
- The fact that the unselected link is ignored across all its patterns.

// File: rtl/alss_pkg.sv
package alss_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DSD  = 2'd1,
        ST_I2S  = 2'd2,
        ST_SWAP = 2'd3
    } route_e;
endpackage

// File: rtl/alss_gate.sv
module alss_gate #(
    parameter int W = 3
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_and
        assign dout[i] = din[i] & en;
    end
endmodule

// File: rtl/alss_fsm.sv
module alss_fsm
    import alss_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   spdif_en,
    input  logic   sel_dsd,
    input  logic   dsd_active,
    input  logic   i2s_active,
    output route_e state
);
    route_e target;
    route_e state_nx;

    always_comb begin
        if (spdif_en)
            target = ST_OFF;
        else if (sel_dsd)
            target = dsd_active ? ST_DSD : ST_OFF;
        else
            target = i2s_active ? ST_I2S : ST_OFF;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  state_nx = target;
            ST_DSD:  state_nx = (target == ST_I2S) ? ST_SWAP : target;
            ST_I2S:  state_nx = (target == ST_DSD) ? ST_SWAP : target;
            ST_SWAP: state_nx = target;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/audio_link_selector.sv
module audio_link_selector
    import alss_pkg::*;
#(
    parameter int NLINES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spdif_en,
    input  logic              sel_dsd,
    input  logic              dsd_active,
    input  logic              i2s_active,
    input  logic [NLINES-1:0] dsd_in,
    input  logic [NLINES-1:0] i2s_in,
    output logic [NLINES-1:0] link_out,
    output logic              fmt_dsd,
    output logic              link_valid
);
    localparam int LW = NLINES;

    route_e        state;
    logic          dsd_en;
    logic          i2s_en;
    logic [LW-1:0] dsd_g;
    logic [LW-1:0] i2s_g;

    alss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .spdif_en   (spdif_en),
        .sel_dsd    (sel_dsd),
        .dsd_active (dsd_active),
        .i2s_active (i2s_active),
        .state      (state)
    );

    // Gate enables: registered route AND live flag AND no S/PDIF takeover
    assign dsd_en = (state == ST_DSD) & dsd_active & ~spdif_en;
    assign i2s_en = (state == ST_I2S) & i2s_active & ~spdif_en;

    alss_gate #(.W(LW)) u_gate_dsd (.din(dsd_in), .en(dsd_en), .dout(dsd_g));
    alss_gate #(.W(LW)) u_gate_i2s (.din(i2s_in), .en(i2s_en), .dout(i2s_g));

    always_comb begin
        link_out   = dsd_g | i2s_g;
        link_valid = 1'b0;
        fmt_dsd    = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_DSD:  begin link_valid = 1'b1; fmt_dsd = 1'b1; end
            ST_I2S:  link_valid = 1'b1;
            ST_SWAP: ;
        endcase
    end
endmodule

// File: rtl/alss_chk.sv
module alss_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spdif_en,
    input logic       sel_dsd,
    input logic       dsd_active,
    input logic       i2s_active,
    input logic [2:0] dsd_in,
    input logic [2:0] i2s_in,
    input logic [2:0] link_out,
    input logic       fmt_dsd,
    input logic       link_valid
);
    // R4
    spdif_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spdif_en |-> (link_out == 3'b000));
    // R4
    spdif_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spdif_en |=> !link_valid);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> (link_out == 3'b000));
    // R2
    dsd_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && fmt_dsd && dsd_active && !spdif_en) |-> (link_out == dsd_in));
    // R3
    i2s_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !fmt_dsd && i2s_active && !spdif_en) |-> (link_out == i2s_in));
    // R7
    swap_dsd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && fmt_dsd && !sel_dsd) |=> !link_valid);
    // R7
    swap_i2s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid && !fmt_dsd && sel_dsd) |=> !link_valid);
    // R8
    fmt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> !fmt_dsd);
endmodule

bind audio_link_selector alss_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spdif_en   (spdif_en),
    .sel_dsd    (sel_dsd),
    .dsd_active (dsd_active),
    .i2s_active (i2s_active),
    .dsd_in     (dsd_in),
    .i2s_in     (i2s_in),
    .link_out   (link_out),
    .fmt_dsd    (fmt_dsd),
    .link_valid (link_valid)
);

// File: tb/sim_audio_link_selector.sv
`timescale 1ns/1ps
module sim_audio_link_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spdif_en = 1'b0, sel_dsd = 1'b0, dsd_active = 1'b0, i2s_active = 1'b0;
    logic [2:0] dsd_in = '0, i2s_in = '0;
    logic [2:0] link_out;
    logic       fmt_dsd, link_valid;
    int         tests = 0, fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    audio_link_selector u0 (
        .clk(clk), .rst_n(rst_n), .spdif_en(spdif_en), .sel_dsd(sel_dsd),
        .dsd_active(dsd_active), .i2s_active(i2s_active),
        .dsd_in(dsd_in), .i2s_in(i2s_in),
        .link_out(link_out), .fmt_dsd(fmt_dsd), .link_valid(link_valid)
    );

    // compare {valid, fmt, lines}
    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {link_valid, fmt_dsd, link_out};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got valid/fmt/lines=%b expected %b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic step(); @(posedge clk); #1; endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        // R1: reset with a live, selected DSD link
        sel_dsd = 1; dsd_active = 1; dsd_in = 3'b111;
        step(); chk("R1", 5'b00000);
        @(negedge clk); rst_n = 1; dsd_active = 0;
        step(); chk("R1", 5'b00000);

        // R9: from ST_OFF one edge to a route
        @(negedge clk); dsd_active = 1;
        #1 chk("R9", 5'b00000);
        step(); chk("R9", {2'b11, 3'b111});

        // R5: flag drops -> lines low same cycle, valid low after edge
        @(negedge clk); dsd_active = 0;
        #1 chk("R5", 5'b11000);
        step(); chk("R5", 5'b00000);

        // R7: swap DSD -> I2S with both live
        @(negedge clk); dsd_active = 1; i2s_active = 1; i2s_in = 3'b101; dsd_in = 3'b011;
        step(); chk("R9", {2'b11, 3'b011});
        @(negedge clk); sel_dsd = 0;
        step(); chk("R7", 5'b00000);
        step(); chk("R7", {2'b10, 3'b101});
        @(negedge clk); sel_dsd = 1;
        step(); chk("R7", 5'b00000);
        step(); chk("R7", {2'b11, 3'b011});

        // R4: spdif takeover same cycle, valid low after edge
        @(negedge clk); spdif_en = 1;
        #1 chk("R4", 5'b11000);
        step(); chk("R4", 5'b00000);
        @(negedge clk); spdif_en = 0;
        step(); chk("R9", {2'b11, 3'b011});

        // Sweep all controls and all line patterns (R2 R3 R4 R5 R6 R8)
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            {spdif_en, sel_dsd, dsd_active, i2s_active} = 4'(c);
            step(); step(); step();
            @(negedge clk);
            for (int v = 0; v < 64; v++) begin
                logic       vld;
                logic [2:0] lines;
                dsd_in = v[2:0];
                i2s_in = v[5:3];
                #0.05;
                vld   = !spdif_en && (sel_dsd ? dsd_active : i2s_active);
                lines = vld ? (sel_dsd ? dsd_in : i2s_in) : 3'b000;
                if (spdif_en)            chk("R4", {vld, vld & sel_dsd, lines});
                else if (!vld)           chk("R5", {vld, 1'b0, lines});
                else if (sel_dsd)        chk("R2 R6 R8", {vld, 1'b1, lines});
                else                     chk("R3 R6 R8", {vld, 1'b0, lines});
            end
        end
        summary();
    end
endmodule